// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block is the host side of a chain of serial 16-bit converters that share one convert line, one serial clock and one return data line; the return line comes from the output of the last converter. Each converter's data input is wired to the output of the converter further up the chain. On a start request the controller raises the convert line while the serial clock is low. This places the chain in shift-register readout mode. It then waits a fixed number of system clocks while the conversions finish.

After the wait it sends one unbroken burst of serial clock pulses, 16 for each converter, and keeps the convert line high for the whole burst. It shifts in one bit at each falling edge of the serial clock. The burst is then split into one 16-bit result per converter according to its position in the stream. At the edge that ends the last pulse, the convert line goes low, the results appear on a wide output bus and a one-cycle strobe marks them. The number of converters, the serial clock high and low times and the conversion wait are all parameters.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is held and after it is released with no start request, cnv_o, sck_o and valid_o are all low.
- R2: A start_i seen at a clock edge while cnv_o is low raises cnv_o at that edge, and sck_o is low in the cycle where cnv_o rises.
- R3: The first rising edge of sck_o comes exactly CONV_CYC + SCK_LO_CYC system clocks after the rising edge of cnv_o. There is no sck_o activity inside the conversion wait.
- R4: Each transaction produces exactly 16 × N_DEV sck_o pulses. Each pulse stays high for SCK_HI_CYC clocks, and each low gap between pulses lasts SCK_LO_CYC clocks.
- R5: cnv_o stays high from its rising edge through the last sck_o falling edge, and sck_o is never high while cnv_o is low.
- R6: sdo_i is sampled at the system clock edge where sck_o falls. The bit sampled there is the one that was present before that fall, so the first sampled bit is the one on the line when the conversion wait ends.
- R7: Bits arrive MSB first. Result k is the k-th group of 16 received bits, with k = 0 being the first group (the converter nearest the host), and it is placed on words_o[16k+15:16k].
- R8: At the edge of the last sck_o fall, cnv_o goes low and valid_o goes high for exactly one cycle. words_o keeps its value until the next transaction begins shifting.
- R9: A start_i that arrives while cnv_o is high has no effect. The transaction in progress keeps its pulse count and timing, and only one valid_o pulse results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion and readback |
| sdo_i | input | 1 | Serial data returned from the end of the chain |
| cnv_o | output | 1 | Convert line shared by all converters |
| sck_o | output | 1 | Serial clock shared by all converters |
| words_o | output | 16*N_DEV | Results, converter k at bits [16k+15:16k] |
| valid_o | output | 1 | One-cycle strobe marking fresh results |

## Verification
Wrong internal state shows at the ports within one transaction. If the bit counter is off by one, the burst has the wrong number of sck_o pulses and every result word is shifted by one bit. This is visible at the valid_o strobe of the same transaction. If the phase counter is wrong, an sck_o high or low time has the wrong width, or the first edge comes at the wrong offset from cnv_o. This shows within a few clocks of the fault. If the sequencer re-arms on a stray start, it adds extra pulses or a second strobe. A monitor counts these against the expected pattern.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chain_rd_sck_gen.sv
module chain_rd_sck_gen #(
  parameter int unsigned SCK_HI_CYC = 2,
  parameter int unsigned SCK_LO_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int unsigned MAX_CYC = (SCK_HI_CYC > SCK_LO_CYC) ? SCK_HI_CYC : SCK_LO_CYC;
  localparam int unsigned PH_W    = $clog2(MAX_CYC + 1);
  localparam logic [PH_W-1:0] HI_LAST = PH_W'(SCK_HI_CYC - 1);
  localparam logic [PH_W-1:0] LO_LAST = PH_W'(SCK_LO_CYC - 1);

  logic            sck_q;
  logic [PH_W-1:0] ph_q;

  // sck falls at the end of the cycle flagged here
  assign fall_o = en_i && sck_q && (ph_q == HI_LAST);
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
    end else if (!en_i) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
    end else if (!sck_q) begin
      if (ph_q == LO_LAST) begin
        sck_q <= 1'b1;
        ph_q  <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end else begin
      if (ph_q == HI_LAST) begin
        sck_q <= 1'b0;
        ph_q  <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  a_r4_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= (sck_q ? HI_LAST : LO_LAST));

  a_r4_no_sck_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sck_q);
endmodule

// File: rtl/chain_rd_capture.sv
module chain_rd_capture
  import chain_rd_pkg::*;
#(
  parameter int unsigned N_DEV = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic                    bit_i,
  output logic [WORD_W*N_DEV-1:0] words_o
);
  localparam int unsigned TOTAL = WORD_W * N_DEV;

  logic [TOTAL-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[TOTAL-2:0], bit_i};
  end

  // earliest group ends at the top of the shift register
  for (genvar k = 0; k < N_DEV; k++) begin : g_unpack
    assign words_o[WORD_W*k +: WORD_W] = sr_q[TOTAL-1-WORD_W*k -: WORD_W];
  end
endmodule

// File: rtl/chain_rd_seq.sv
module chain_rd_seq
  import chain_rd_pkg::*;
#(
  parameter int unsigned N_DEV    = 3,
  parameter int unsigned CONV_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fall_i,
  output logic cnv_o,
  output logic shift_en_o,
  output logic valid_o
);
  localparam int unsigned TOTAL = WORD_W * N_DEV;
  localparam int unsigned CNT_W = $clog2(CONV_CYC + 1);
  localparam int unsigned BIT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(TOTAL - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] conv_cnt_q;
  logic [BIT_W-1:0] bit_cnt_q;
  logic             cnv_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      conv_cnt_q <= '0;
      bit_cnt_q  <= '0;
      cnv_q      <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_CONV;
            cnv_q      <= 1'b1;
            conv_cnt_q <= '0;
            bit_cnt_q  <= '0;
          end
        end
        ST_CONV: begin
          if (conv_cnt_q == CONV_LAST) state_q <= ST_SHIFT;
          else                         conv_cnt_q <= conv_cnt_q + 1'b1;
        end
        ST_SHIFT: begin
          if (fall_i) begin
            if (bit_cnt_q == BIT_LAST) begin
              state_q <= ST_IDLE;
              cnv_q   <= 1'b0;
              valid_q <= 1'b1;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o      = cnv_q;
  assign valid_o    = valid_q;
  assign shift_en_o = (state_q == ST_SHIFT);

  a_r9_start_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && start_i && !fall_i) |=> $stable(bit_cnt_q));

  a_r3_no_shift_before_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_q) |-> state_q == ST_CONV && conv_cnt_q == '0);

  a_r4_bit_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= BIT_LAST);
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_rd_pkg::*;
#(
  parameter int unsigned N_DEV      = 3,
  parameter int unsigned SCK_HI_CYC = 2,
  parameter int unsigned SCK_LO_CYC = 3,
  parameter int unsigned CONV_CYC   = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    sdo_i,
  output logic                    cnv_o,
  output logic                    sck_o,
  output logic [16*N_DEV-1:0]     words_o,
  output logic                    valid_o
);
  logic shift_en;
  logic sck_fall;

  chain_rd_seq #(
    .N_DEV   (N_DEV),
    .CONV_CYC(CONV_CYC)
  ) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .fall_i    (sck_fall),
    .cnv_o     (cnv_o),
    .shift_en_o(shift_en),
    .valid_o   (valid_o)
  );

  chain_rd_sck_gen #(
    .SCK_HI_CYC(SCK_HI_CYC),
    .SCK_LO_CYC(SCK_LO_CYC)
  ) sck_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .sck_o (sck_o),
    .fall_o(sck_fall)
  );

  chain_rd_capture #(
    .N_DEV(N_DEV)
  ) cap_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sck_fall),
    .bit_i  (sdo_i),
    .words_o(words_o)
  );

  a_r2_sck_low_at_cnv_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> !sck_o);

  a_r5_sck_inside_cnv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> cnv_o);

  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_cnv_fall_marks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> valid_o);
endmodule

// File: tb/chain_adc_reader_tb_top.sv
module chain_adc_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV      = 3;
  localparam int HI         = 2;
  localparam int LO         = 3;
  localparam int CONV       = 20;
  localparam int TOT        = 16 * N_DEV;
  localparam int WDOG       = 50000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           sdo;
  logic           cnv, sck, valid;
  logic [TOT-1:0] words;

  logic [TOT-1:0] stream = '0;
  int             idx = 0;
  int             n_chk = 0;
  int             n_fail = 0;
  int             n_valid = 0;
  int             n_push = 0;
  logic [TOT-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_adc_reader #(
    .N_DEV(N_DEV), .SCK_HI_CYC(HI), .SCK_LO_CYC(LO), .CONV_CYC(CONV)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdo_i(sdo),
    .cnv_o(cnv), .sck_o(sck), .words_o(words), .valid_o(valid)
  );

  // chain model: first group is the nearest converter, MSB first
  assign sdo = (idx < TOT) ? stream[TOT-1-idx] : 1'b0;
  always @(posedge cnv) idx = 0;
  always @(negedge sck) #1 idx = idx + 1;

  task automatic check(input bit ok, input string req, input logic [TOT-1:0] act,
                       input logic [TOT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor, sampled at falling clock edge
  bit prev_cnv = 0, prev_sck = 0, prev_valid = 0, first_rise = 0;
  int cyc = 0, pulses = 0, run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      run++;
      if (cnv && !prev_cnv) begin
        check(!sck, "R2 sck low at cnv rise", TOT'(sck), '0);
        cyc = 0; pulses = 0; first_rise = 1;
      end else if (cnv) cyc++;
      if (sck && !prev_sck) begin
        pulses++;
        if (first_rise) begin
          check(cyc == CONV + LO, "R3 first sck edge offset", TOT'(cyc), TOT'(CONV + LO));
          first_rise = 0;
        end else begin
          check(run == LO, "R4 sck low time", TOT'(run), TOT'(LO));
        end
        run = 0;
      end
      if (!sck && prev_sck) begin
        check(run == HI, "R4 sck high time", TOT'(run), TOT'(HI));
        run = 0;
      end
      if (sck && !cnv) check(0, "R5 sck outside cnv", 1, 0);
      if (valid) begin
        n_valid++;
        check(!prev_valid, "R8 valid one cycle", 1, 0);
        check(!cnv, "R8 cnv low with valid", TOT'(cnv), '0);
        check(pulses == TOT, "R4 pulse count", TOT'(pulses), TOT'(TOT));
        if (exp_q.size() == 0) check(0, "R9 unexpected valid", words, '0);
        else begin
          logic [TOT-1:0] e;
          e = exp_q.pop_front();
          check(words == e, "R7 R6 result words", words, e);
        end
      end
      prev_cnv = cnv; prev_sck = sck; prev_valid = valid;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_txn(input logic [TOT-1:0] s, input int extra_start_at);
    logic [TOT-1:0] e;
    stream = s;
    for (int k = 0; k < N_DEV; k++) e[16*k +: 16] = s[TOT-1-16*k -: 16];
    exp_q.push_back(e);
    n_push++;
    pulse_start();
    if (extra_start_at > 0) begin
      repeat (extra_start_at) @(negedge clk);
      pulse_start(); // R9: ignored while busy
    end
    @(posedge valid);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [TOT-1:0] held;
    repeat (3) @(negedge clk);
    check(!cnv && !sck && !valid, "R1 outputs in reset", {cnv, sck, valid}, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!cnv && !sck && !valid, "R1 idle after reset", {cnv, sck, valid}, '0);

    run_txn({16'hA5C3, 16'h0001, 16'h8000}, 0);
    run_txn({16'hFFFF, 16'h0000, 16'hFFFF}, 0);
    run_txn({16'h1234, 16'h5678, 16'h9ABC}, 5);    // R9 start during conversion wait
    run_txn({16'h0F0F, 16'hF0F0, 16'h7FFE}, 100);  // R9 start during shifting
    held = words;
    repeat (30) @(negedge clk);
    check(words == held, "R8 words held while idle", words, held);
    check(!cnv && !sck, "R8 idle after done", {cnv, sck}, '0);
    check(n_valid == n_push, "R9 one valid per request", TOT'(n_valid), TOT'(n_push));
    check(exp_q.size() == 0, "R7 all results seen", TOT'(exp_q.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule